// File: doc/BRIEF.md
# Calibration Coefficient Memory Access Controller

This block sits between a host register interface and a slow, byte-wide, non-volatile store that holds calibration coefficients. The host writes one 16-bit access word that names a byte address and says whether to fetch or store a byte. The access word also carries the byte to store. The host then polls a read-only status word. That word shows whether a fetch has finished, whether a store is still running, and whether a request was thrown away. It also holds the fetched byte. The store is modelled as a byte array. Its fetch and store latencies, and the access window opened by every status read, are parameters counted in clock cycles.

Each 16-bit coefficient occupies two bytes. The most significant byte sits at the even address and the least significant byte at the odd address after it. Each channel has an offset coefficient and a gain coefficient, so it owns four bytes. There are eight channels for each of three ranges. Storing a byte requires that a key register first hold the unlock code. Both a synchronous software reset and the asynchronous hardware reset clear the status word. Neither reset changes the access register.

Top module: `coef_mem_ctrl`

## Requirements
- R1: After hardware reset, and after a software reset pulse, the status word reads 0x0000. Its fields are: bit 0 fetch done, bit 1 store busy, bit 2 drop error, bits 15:8 fetched byte, bits 7:3 always 0.
- R2: An access write with bit 15 = 1 starts a fetch from the address in bits 14:8. Bit 0 reads 0 from the cycle after the request until RD_LAT cycles after it. Bit 0 then reads 1, with the byte on bits 15:8.
- R3: An access write with bit 15 = 0 and bits 7:0 as data starts a store, provided the key register holds 0xC0DE. Bit 1 reads 1 for exactly WR_LAT cycles starting the cycle after the request. The byte is in the store when bit 1 falls.
- R4: A store request made while the key register holds any other value is ignored. Bit 1 stays 0 and the addressed byte keeps its old value.
- R5: A fetch from an address above 0x5F returns 0xFF. A store to such an address is ignored, and bit 1 stays 0.
- R6: A status read strobe opens an access window that covers the next WIN_LAT request edges. A request that lands in the window is dropped. A request one edge later is accepted.
- R7: A request that arrives while a fetch or store is running is dropped, and the running operation carries on. Any dropped request sets bit 2, which then stays set until a reset.
- R8: A software reset aborts a running store before it reaches the store. Neither reset alters the access register readback. Either reset also clears the key register.
- R9: A coefficient for range r (0..2), channel c (0..7) and kind k (0 offset, 1 gain) has its high byte at r*0x20 + c*4 + k*2 and its low byte at the next address. Both bytes read back as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset pulse |
| acc_wr_i | input | 1 | Write strobe for the access register |
| acc_wdata_i | input | 16 | Access word: bit 15 fetch/store, 14:8 address, 7:0 store data |
| acc_rdata_o | output | 16 | Access register readback |
| key_wr_i | input | 1 | Write strobe for the key register |
| key_wdata_i | input | 16 | Key value |
| stat_rd_i | input | 1 | Host status read strobe, opens the access window |
| stat_rdata_o | output | 16 | Status word |

## Verification
The bench probes both edges of the access window. A request on the last window edge must be dropped, and one on the following edge accepted. An off-by-one counter would accept the first or reject the second. Fetch-done and store-busy are sampled one cycle before and at their expected transition, so a latency that is one cycle short or long shows up. Several cases target the store path: stores with a wrong key, stores past 0x5F, and a store aborted by software reset. A design that let any of these reach the store would fail the readback that follows. Error stickiness and preservation of the access register across both resets are checked after each reset.

// File: rtl/coef_pkg.sv
package coef_pkg;

  // Address field width of the access word and coefficient layout.
  localparam int ADDR_W       = 7;
  localparam int DATA_W       = 8;
  localparam int N_CHAN       = 8;
  localparam int N_RANGE      = 3;
  localparam int BYTES_PER_CH = 4;
  localparam int RANGE_STRIDE = N_CHAN * BYTES_PER_CH;
  localparam int COEF_DEPTH   = N_RANGE * RANGE_STRIDE;

  // Status word bit positions.
  localparam int ST_DONE = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_ERR  = 2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic              rd_nwr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } acc_req_t;

endpackage

// File: rtl/coef_seq.sv
module coef_seq
  import coef_pkg::*;
#(
  parameter int RD_LAT  = 5,
  parameter int WR_LAT  = 10,
  parameter int WIN_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              req_vld_i,
  input  acc_req_t          req_i,
  input  logic              key_ok_i,
  input  logic              addr_ok_i,
  input  logic              stat_rd_i,
  output logic              rd_start_o,
  output logic              rd_fin_o,
  output logic              wr_start_o,
  output logic              wr_fin_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);

  localparam int OP_MAX = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CW     = (OP_MAX  < 2) ? 1 : $clog2(OP_MAX);
  localparam int WW     = (WIN_LAT < 2) ? 1 : $clog2(WIN_LAT);

  seq_st_e           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              win_q, win_d;
  logic [WW-1:0]     wcnt_q, wcnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              blocked;
  logic              accept;

  assign blocked    = (st_q != SQ_IDLE) || win_q;
  assign accept     = req_vld_i && !blocked;
  assign drop_o     = req_vld_i && blocked;
  assign rd_start_o = accept && req_i.rd_nwr;
  assign wr_start_o = accept && !req_i.rd_nwr && key_ok_i && addr_ok_i;
  assign rd_fin_o   = (st_q == SQ_READ)  && (cnt_q == '0);
  assign wr_fin_o   = (st_q == SQ_WRITE) && (cnt_q == '0);
  assign op_addr_o  = addr_q;
  assign op_data_o  = data_q;

  // Operation sequencer next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    if (soft_rst_i) begin
      st_d  = SQ_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (rd_start_o) begin
            st_d   = SQ_READ;
            cnt_d  = CW'(RD_LAT - 1);
            addr_d = req_i.addr;
          end else if (wr_start_o) begin
            st_d   = SQ_WRITE;
            cnt_d  = CW'(WR_LAT - 1);
            addr_d = req_i.addr;
            data_d = req_i.data;
          end
        end
        SQ_READ, SQ_WRITE: begin
          if (cnt_q == '0) st_d = SQ_IDLE;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  // Access window next state
  always_comb begin
    win_d  = win_q;
    wcnt_d = wcnt_q;
    if (soft_rst_i) begin
      win_d  = 1'b0;
      wcnt_d = '0;
    end else if (stat_rd_i) begin
      win_d  = 1'b1;
      wcnt_d = WW'(WIN_LAT - 1);
    end else if (win_q) begin
      if (wcnt_q == '0) win_d = 1'b0;
      else              wcnt_d = wcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      win_q  <= 1'b0;
      wcnt_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      win_q  <= win_d;
      wcnt_q <= wcnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/coef_store.sv
module coef_store
  import coef_pkg::*;
#(
  parameter int DEPTH = COEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_rng;

  assign in_rng  = ({1'b0, addr_i} < (ADDR_W+1)'(DEPTH));
  assign rdata_o = in_rng ? mem[addr_i] : {DATA_W{1'b1}};

  // Non-volatile contents: no reset.
  always_ff @(posedge clk_i) begin
    if (we_i && in_rng) mem[addr_i] <= wdata_i;
  end

endmodule

// File: rtl/coef_stat.sv
module coef_stat
  import coef_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              rd_start_i,
  input  logic              rd_fin_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  input  logic              wr_start_i,
  input  logic              wr_fin_i,
  input  logic              drop_i,
  output logic [15:0]       stat_o
);

  logic [DATA_W-1:0] byte_q, byte_d;
  logic              done_q, done_d;
  logic              busy_q, busy_d;
  logic              err_q,  err_d;

  always_comb begin
    byte_d = byte_q;
    done_d = done_q;
    busy_d = busy_q;
    err_d  = err_q;
    if (soft_rst_i) begin
      byte_d = '0;
      done_d = 1'b0;
      busy_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (rd_start_i) done_d = 1'b0;
      if (rd_fin_i) begin
        done_d = 1'b1;
        byte_d = rd_byte_i;
      end
      if (wr_start_i) busy_d = 1'b1;
      if (wr_fin_i)   busy_d = 1'b0;
      if (drop_i)     err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      byte_q <= byte_d;
      done_q <= done_d;
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[15:8]    = byte_q;
    stat_o[ST_DONE] = done_q;
    stat_o[ST_BUSY] = busy_q;
    stat_o[ST_ERR]  = err_q;
  end

endmodule

// File: rtl/coef_mem_ctrl.sv
module coef_mem_ctrl
  import coef_pkg::*;
#(
  parameter int          RD_LAT  = 5,
  parameter int          WR_LAT  = 10,
  parameter int          WIN_LAT = 4,
  parameter int          DEPTH   = COEF_DEPTH,
  parameter logic [15:0] WR_KEY  = 16'hC0DE
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        soft_rst_i,
  input  logic        acc_wr_i,
  input  logic [15:0] acc_wdata_i,
  output logic [15:0] acc_rdata_o,
  input  logic        key_wr_i,
  input  logic [15:0] key_wdata_i,
  input  logic        stat_rd_i,
  output logic [15:0] stat_rdata_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [15:0]       acc_q;
  logic [15:0]       key_q, key_d;
  logic              key_ok;
  logic              addr_ok;
  acc_req_t          req;
  logic              rd_start, rd_fin, wr_start, wr_fin, drop;
  logic              mem_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] rd_byte;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // Access register: untouched by any reset.
  always_ff @(posedge clk_i) begin
    if (acc_wr_i) acc_q <= acc_wdata_i;
  end
  assign acc_rdata_o = acc_q;

  // Key register
  always_comb begin
    key_d = key_q;
    if (soft_rst_i)    key_d = '0;
    else if (key_wr_i) key_d = key_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  assign key_ok  = (key_q == WR_KEY);
  assign req     = acc_req_t'(acc_wdata_i);
  assign addr_ok = ({1'b0, req.addr} < (ADDR_W+1)'(DEPTH));
  assign mem_we  = wr_fin && !soft_rst_i;

  coef_seq #(
    .RD_LAT  (RD_LAT),
    .WR_LAT  (WR_LAT),
    .WIN_LAT (WIN_LAT)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .req_vld_i  (acc_wr_i),
    .req_i      (req),
    .key_ok_i   (key_ok),
    .addr_ok_i  (addr_ok),
    .stat_rd_i  (stat_rd_i),
    .rd_start_o (rd_start),
    .rd_fin_o   (rd_fin),
    .wr_start_o (wr_start),
    .wr_fin_o   (wr_fin),
    .drop_o     (drop),
    .op_addr_o  (op_addr),
    .op_data_o  (op_data)
  );

  coef_store #(
    .DEPTH (DEPTH)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (op_addr),
    .wdata_i (op_data),
    .rdata_o (rd_byte)
  );

  coef_stat u_stat (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .rd_start_i (rd_start),
    .rd_fin_i   (rd_fin),
    .rd_byte_i  (rd_byte),
    .wr_start_i (wr_start),
    .wr_fin_i   (wr_fin),
    .drop_i     (drop),
    .stat_o     (stat_rdata_o)
  );

endmodule

// File: rtl/coef_mem_ctrl_chk.sv
module coef_mem_ctrl_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        soft_rst_i,
  input logic        acc_wr_i,
  input logic [15:0] acc_rdata_o,
  input logic [15:0] stat_rdata_o,
  input logic        rd_fin,
  input logic        key_ok
);

  // R1: a software reset pulse clears the flag bits on the next edge
  a_r1_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_n)
    soft_rst_i |=> (stat_rdata_o[2:0] == 3'b000));

  // R2: fetch-done only rises when the sequencer finishes a fetch
  a_r2_done_from_fetch: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(stat_rdata_o[0]) |-> $past(rd_fin));

  // R3: store-busy only rises while the key register held the unlock code
  a_r3_busy_needs_key: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(stat_rdata_o[1]) |-> $past(key_ok));

  // R7: the drop error bit is sticky until a reset
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stat_rdata_o[2] && !soft_rst_i) |=> stat_rdata_o[2]);

  // R8: the access register only changes on its own write strobe
  a_r8_acc_held: assert property (@(posedge clk_i) disable iff (!rst_n)
    !acc_wr_i |=> $stable(acc_rdata_o));

endmodule

bind coef_mem_ctrl coef_mem_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .soft_rst_i   (soft_rst_i),
  .acc_wr_i     (acc_wr_i),
  .acc_rdata_o  (acc_rdata_o),
  .stat_rdata_o (stat_rdata_o),
  .rd_fin       (rd_fin),
  .key_ok       (key_ok)
);

// File: tb/sim_coef_mem_ctrl.sv
`timescale 1ns/1ps
module sim_coef_mem_ctrl;

  localparam int RD_LAT  = 5;
  localparam int WR_LAT  = 10;
  localparam int WIN_LAT = 4;
  localparam logic [15:0] KEY = 16'hC0DE;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        soft_rst_i;
  logic        acc_wr_i;
  logic [15:0] acc_wdata_i;
  logic [15:0] acc_rdata_o;
  logic        key_wr_i;
  logic [15:0] key_wdata_i;
  logic        stat_rd_i;
  logic [15:0] stat_rdata_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] model [128];
  bit         known [128];

  always #2 clk_i = ~clk_i;

  coef_mem_ctrl #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .WIN_LAT(WIN_LAT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .acc_wr_i(acc_wr_i), .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o),
    .key_wr_i(key_wr_i), .key_wdata_i(key_wdata_i),
    .stat_rd_i(stat_rd_i), .stat_rdata_o(stat_rdata_o));

  function automatic logic [6:0] byte_addr(int r, int c, int k, int lo);
    return 7'(r * 32 + c * 4 + k * 2 + lo);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // All drive tasks start and end at a falling edge.
  task automatic acc_req(input bit rd, input logic [6:0] a, input logic [7:0] d);
    acc_wr_i = 1'b1; acc_wdata_i = {rd, a, d};
    @(negedge clk_i);
    acc_wr_i = 1'b0;
  endtask

  task automatic set_key(input logic [15:0] k);
    key_wr_i = 1'b1; key_wdata_i = k;
    @(negedge clk_i);
    key_wr_i = 1'b0;
  endtask

  task automatic soft_reset();
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0;
  endtask

  task automatic stat_read();
    stat_rd_i = 1'b1;
    @(negedge clk_i);
    stat_rd_i = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [6:0] a, input logic [7:0] exp);
    acc_req(1'b1, a, 8'h00);
    chk({req, " done cleared"}, 32'(stat_rdata_o[0]), 32'd0);
    repeat (RD_LAT - 1) @(negedge clk_i);
    chk({req, " done not early"}, 32'(stat_rdata_o[0]), 32'd0);
    @(negedge clk_i);
    chk({req, " done set"}, 32'(stat_rdata_o[0]), 32'd1);
    chk({req, " byte"}, 32'(stat_rdata_o[15:8]), 32'(exp));
  endtask

  task automatic do_write(input string req, input logic [6:0] a, input logic [7:0] d, input bit takes);
    acc_req(1'b0, a, d);
    if (takes) begin
      chk({req, " busy rises"}, 32'(stat_rdata_o[1]), 32'd1);
      repeat (WR_LAT - 1) @(negedge clk_i);
      chk({req, " busy held"}, 32'(stat_rdata_o[1]), 32'd1);
      @(negedge clk_i);
      chk({req, " busy falls"}, 32'(stat_rdata_o[1]), 32'd0);
      model[a] = d; known[a] = 1'b1;
    end else begin
      chk({req, " busy stays low"}, 32'(stat_rdata_o[1]), 32'd0);
      repeat (2) @(negedge clk_i);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [15:0] held;
    int unsigned seed;
    seed = $urandom(32'd1234);
    rst_ni = 1'b0; soft_rst_i = 1'b0; acc_wr_i = 1'b0; acc_wdata_i = '0;
    key_wr_i = 1'b0; key_wdata_i = '0; stat_rd_i = 1'b0;
    for (int i = 0; i < 128; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 hw reset status", 32'(stat_rdata_o), 32'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 status after release", 32'(stat_rdata_o), 32'h0);

    // R4: store without key is ignored
    do_write("R4 no key", 7'h10, 8'hAA, 1'b0);
    set_key(KEY);
    do_write("R3 store", 7'h10, 8'h5C, 1'b1);
    do_read("R2 fetch", 7'h10, 8'h5C);
    set_key(16'h1234);
    do_write("R4 wrong key", 7'h10, 8'h33, 1'b0);
    do_read("R4 unchanged", 7'h10, 8'h5C);
    set_key(KEY);

    // R5: out-of-range
    do_write("R5 store 0x60", 7'h60, 8'h11, 1'b0);
    do_read("R5 fetch 0x60", 7'h60, 8'hFF);
    do_read("R5 fetch 0x7F", 7'h7F, 8'hFF);
    do_write("R5 last valid 0x5F", 7'h5F, 8'h42, 1'b1);
    do_read("R5 fetch 0x5F", 7'h5F, 8'h42);
    chk("R7 no error yet", 32'(stat_rdata_o[2]), 32'd0);

    // R7: request during a running store is dropped
    acc_req(1'b0, 7'h20, 8'h77);
    model[7'h20] = 8'h77; known[7'h20] = 1'b1;
    acc_req(1'b1, 7'h10, 8'h00);
    chk("R7 drop sets error", 32'(stat_rdata_o[2]), 32'd1);
    chk("R7 store still busy", 32'(stat_rdata_o[1]), 32'd1);
    repeat (WR_LAT) @(negedge clk_i);
    chk("R7 store completes", 32'(stat_rdata_o[1]), 32'd0);
    chk("R7 error sticky", 32'(stat_rdata_o[2]), 32'd1);
    do_read("R7 store landed", 7'h20, 8'h77);
    chk("R7 error still sticky", 32'(stat_rdata_o[2]), 32'd1);

    // R1/R8: software reset clears status, keeps access register
    held = acc_rdata_o;
    soft_reset();
    chk("R1 soft reset status", 32'(stat_rdata_o), 32'h0);
    chk("R8 acc kept soft", 32'(acc_rdata_o), 32'(held));
    do_write("R8 key cleared by reset", 7'h20, 8'h01, 1'b0);
    set_key(KEY);

    // R6: access window edges
    stat_read();
    acc_req(1'b1, 7'h10, 8'h00);
    chk("R6 drop first edge", 32'(stat_rdata_o[2]), 32'd1);
    soft_reset(); set_key(KEY);
    stat_read();
    repeat (WIN_LAT - 1) @(negedge clk_i);
    acc_req(1'b1, 7'h10, 8'h00);
    chk("R6 drop last edge", 32'(stat_rdata_o[2]), 32'd1);
    soft_reset(); set_key(KEY);
    stat_read();
    repeat (WIN_LAT) @(negedge clk_i);
    do_read("R6 accept after window", 7'h10, 8'h5C);
    chk("R6 no error", 32'(stat_rdata_o[2]), 32'd0);

    // R8: soft reset aborts a store
    acc_req(1'b0, 7'h10, 8'hE1);
    repeat (3) @(negedge clk_i);
    soft_reset();
    chk("R8 abort clears busy", 32'(stat_rdata_o[1]), 32'd0);
    do_read("R8 aborted store absent", 7'h10, 8'h5C);
    set_key(KEY);

    // R9: random coefficients at computed addresses
    for (int n = 0; n < 24; n++) begin
      int r, c, k;
      logic [15:0] v;
      r = int'($urandom % 3); c = int'($urandom % 8); k = int'($urandom % 2);
      v = 16'($urandom);
      if (($urandom % 5) == 0) begin
        set_key(16'h0BAD);
        do_write("R4 random bad key", byte_addr(r, c, k, 0), ~v[15:8], 1'b0);
        set_key(KEY);
      end
      do_write("R9 hi store", byte_addr(r, c, k, 0), v[15:8], 1'b1);
      do_write("R9 lo store", byte_addr(r, c, k, 1), v[7:0], 1'b1);
      do_read("R9 hi fetch", byte_addr(r, c, k, 0), v[15:8]);
      do_read("R9 lo fetch", byte_addr(r, c, k, 1), v[7:0]);
    end
    do_read("R9 corner last gain lo", byte_addr(2, 7, 1, 1), known[7'h5F] ? model[7'h5F] : 8'h42);

    // R8: hardware reset keeps access register
    held = acc_rdata_o;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 hw reset mid-run", 32'(stat_rdata_o), 32'h0);
    chk("R8 acc kept hw", 32'(acc_rdata_o), 32'(held));
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    do_write("R8 key cleared by hw reset", 7'h00, 8'h9, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule